// File: doc/BRIEF.md
# Asynchronous Static RAM Cycle Controller

This block turns single-word read and write requests from a synchronous user into properly timed strobe sequences on an asynchronous static RAM port with a 12-bit address and an 8-bit data path. Each memory timing minimum is supplied as a parameter in whole clock cycles. A down-counter, loaded whenever a state is entered, holds each phase for the required number of cycles.

The user raises `req` while `ready` is high and gives `we`, `addr` and `wdata`. The controller registers the address and data. It then drives active-low chip select, write strobe and output enable. For a write it also drives the data path and its direction control. When the cycle ends it produces a one-cycle `done`; for a read, `rdata` is valid at that point. The length of the write strobe depends on whether output enable is held asserted during writes. If it is, the RAM's output drivers must turn off before the controller drives the bus, so the pulse is stretched to cover that turn-off time plus the data setup time.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_we_n` and `mem_oe_n` are 1, `mem_dq_oe` is 0, `done` is 0 and `ready` is 1.
- R2: A read holds `mem_ce_n` and `mem_oe_n` low, with `mem_we_n` high, for exactly RD_CYC cycles. `rdata` takes the bus value sampled on the last of those cycles and is valid while `done` is high.
- R3: `mem_we_n` is low only while `mem_ce_n` is low. The pulse lasts exactly max(WP_CYC, WZ_CYC+DSU_CYC) cycles when OE_WR_LOW=1, or max(WP_CYC, DSU_CYC) cycles when OE_WR_LOW=0.
- R4: `mem_dq_oe` is never 1 while the RAM may be driving, that is while `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1. With OE_WR_LOW=1, driving starts WZ_CYC cycles into the write pulse. Driving covers at least DSU_CYC cycles before the pulse ends and continues for one cycle after it.
- R5: `mem_addr` changes only while `mem_ce_n` is high. During a cycle it equals the address given with the accepted request.
- R6: A request is taken only while `ready` is 1. A `req` held during a busy cycle neither changes `mem_addr` nor writes memory.
- R7: Between two cycles, `mem_ce_n` stays high for at least REC_CYC+1 cycles, and `ready` is low during the REC_CYC recovery cycles.
- R8: `done` is high for exactly one cycle per request, on the first cycle after chip select is released. `ready` is low from the cycle after acceptance until the controller is idle again.
- R9: For a write, `mem_ce_n` is low for exactly one address-setup cycle plus the write pulse length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start a cycle (taken when ready) |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 12 | Word address |
| wdata | input | 8 | Write data |
| ready | output | 1 | Idle, request will be taken |
| done | output | 1 | One-cycle end-of-cycle pulse |
| rdata | output | 8 | Read data, valid with done |
| mem_addr | output | 12 | RAM address |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_out | output | 8 | Data driven toward the RAM |
| mem_dq_oe | output | 1 | 1 = controller drives the data path |
| mem_dq_in | input | 8 | Data returned from the RAM |

## Verification
The assertions assume that `req` is only an intent and that the controller alone decides when to take it. They also assume that `mem_dq_in` matters only on the sampling cycle of a read. The bench changes inputs on falling edges only. It keeps the parameters in the ordering the counters need: RD_CYC and REC_CYC at least 1, and the pulse at least DSU_CYC long. Its RAM model turns its outputs off exactly WZ_CYC cycles after the write strobe falls and returns the placeholder 8'hEE until RD_CYC cycles of access have passed. Any early sample, short pulse, short setup or address movement therefore appears as a wrong value or a model violation.

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl #(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int RD_CYC    = 3,
  parameter int WP_CYC    = 2,
  parameter int WZ_CYC    = 2,
  parameter int DSU_CYC   = 2,
  parameter int REC_CYC   = 1,
  parameter int OE_WR_LOW = 1,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic              done,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);
  localparam int WZ_EFF  = (OE_WR_LOW != 0) ? WZ_CYC : 0;
  localparam int PW_LEN  = (WZ_EFF + DSU_CYC > WP_CYC) ? WZ_EFF + DSU_CYC : WP_CYC;
  localparam int RD_LEN  = (RD_CYC < 1) ? 1 : RD_CYC;
  localparam int REC_LEN = (REC_CYC < 1) ? 1 : REC_CYC;
  localparam logic [CNT_W-1:0] RD_LD   = CNT_W'(RD_LEN - 1);
  localparam logic [CNT_W-1:0] PW_LD   = CNT_W'(PW_LEN - 1);
  localparam logic [CNT_W-1:0] REC_LD  = CNT_W'(REC_LEN - 1);
  localparam logic [CNT_W-1:0] DRV_LIM = CNT_W'(PW_LEN - WZ_EFF);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WSU, S_WP, S_REC} state_t;

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic              hold;
  logic [DATA_W-1:0] wd_q;

  assign ready      = (state == S_IDLE);
  assign mem_dq_out = wd_q;
  assign mem_dq_oe  = hold || (state == S_WP && cnt < DRV_LIM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      hold     <= 1'b0;
      done     <= 1'b0;
      mem_ce_n <= 1'b1;
      mem_we_n <= 1'b1;
      mem_oe_n <= 1'b1;
      mem_addr <= '0;
      wd_q     <= '0;
      rdata    <= '0;
    end else begin
      done <= 1'b0;
      hold <= 1'b0;
      case (state)
        S_IDLE: if (req) begin
          mem_addr <= addr;
          mem_ce_n <= 1'b0;
          if (we) begin
            wd_q     <= wdata;
            mem_oe_n <= (OE_WR_LOW == 0);
            state    <= S_WSU;
          end else begin
            mem_oe_n <= 1'b0;
            cnt      <= RD_LD;
            state    <= S_RD;
          end
        end
        S_RD: if (cnt == '0) begin
          rdata    <= mem_dq_in;
          done     <= 1'b1;
          mem_ce_n <= 1'b1;
          mem_oe_n <= 1'b1;
          cnt      <= REC_LD;
          state    <= S_REC;
        end else cnt <= cnt - 1'b1;
        S_WSU: begin
          mem_we_n <= 1'b0;
          cnt      <= PW_LD;
          state    <= S_WP;
        end
        S_WP: if (cnt == '0) begin
          mem_we_n <= 1'b1;
          mem_ce_n <= 1'b1;
          mem_oe_n <= 1'b1;
          done     <= 1'b1;
          hold     <= 1'b1;
          cnt      <= REC_LD;
          state    <= S_REC;
        end else cnt <= cnt - 1'b1;
        S_REC: if (cnt == '0) state <= S_IDLE;
               else cnt <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
  parameter int ADDR_W    = 12,
  parameter int WP_CYC    = 2,
  parameter int WZ_CYC    = 2,
  parameter int DSU_CYC   = 2,
  parameter int OE_WR_LOW = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req,
  input logic              ready,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic              mem_dq_oe
);
  localparam int WZE = (OE_WR_LOW != 0) ? WZ_CYC : 0;
  localparam int PW  = (WZE + DSU_CYC > WP_CYC) ? WZE + DSU_CYC : WP_CYC;

  logic [15:0] wl;
  always_ff @(posedge clk)
    if (!rst_n) wl <= '0;
    else        wl <= mem_we_n ? 16'd0 : wl + 16'd1;

  p_we_in_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);
  p_pulse_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (wl == 16'(PW)));
  p_no_fight_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> (mem_ce_n || mem_oe_n || !mem_we_n));
  p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |=> $stable(mem_addr));
  p_take_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> $past(req));
  p_ce_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ce_n) |=> mem_ce_n);
  p_done_one_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(
  .ADDR_W(ADDR_W), .WP_CYC(WP_CYC), .WZ_CYC(WZ_CYC),
  .DSU_CYC(DSU_CYC), .OE_WR_LOW(OE_WR_LOW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .ready(ready), .done(done),
  .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n),
  .mem_oe_n(mem_oe_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/test_sram_cycle_ctrl.sv
module test_sram_cycle_ctrl;
  localparam int RD = 3, WP = 2, WZ = 2, DSU = 2, REC = 2;
  localparam int PW = (WZ + DSU > WP) ? WZ + DSU : WP;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, we = 1'b0;
  logic [11:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic ready, done, ce_n, we_n, oe_n, dq_oe;
  logic [7:0]  rdata, dq_out, dq_in;
  logic [11:0] maddr;
  int nvec = 0, nerr = 0, viol = 0;

  always #5 clk = ~clk;

  sram_cycle_ctrl #(.RD_CYC(RD), .WP_CYC(WP), .WZ_CYC(WZ), .DSU_CYC(DSU),
                    .REC_CYC(REC), .OE_WR_LOW(1)) i_sram_cycle_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .wdata(wdata),
    .ready(ready), .done(done), .rdata(rdata), .mem_addr(maddr),
    .mem_ce_n(ce_n), .mem_we_n(we_n), .mem_oe_n(oe_n), .mem_dq_out(dq_out),
    .mem_dq_oe(dq_oe), .mem_dq_in(dq_in));

  // RAM model with timing rule checks
  logic [7:0]  mem [4096];
  logic [7:0]  lat;
  logic [11:0] paddr;
  logic        pce_n = 1'b1, pwe_n = 1'b1;
  int acc = 0, wlow = 0, dv = 0;
  wire ram_drv = !ce_n && !oe_n && (we_n || wlow < WZ);
  assign dq_in = (!ce_n && !oe_n && we_n && acc >= RD - 1) ? mem[maddr] : 8'hEE;

  always @(posedge clk) begin
    if (rst_n) begin
      if (!pce_n && !pwe_n && maddr != paddr) viol = viol + 1;
      if (!ce_n && !oe_n && we_n) acc = acc + 1; else acc = 0;
      if (!ce_n && !we_n) begin
        wlow = wlow + 1;
        if (dq_oe) begin dv = dv + 1; lat = dq_out; end else dv = 0;
      end else if (!pwe_n && !pce_n) begin
        if (wlow < WP || dv < DSU) viol = viol + 1;
        else mem[paddr] = lat;
        wlow = 0; dv = 0;
      end
    end
    pce_n = ce_n; pwe_n = we_n; paddr = maddr;
  end
  always @(negedge clk) if (rst_n && ram_drv && dq_oe) viol = viol + 1;

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    nvec++;
    if (!ok) begin nerr++; $display("FAIL %s actual=%0h expected=%0h", rq, act, exp); end
  endtask

  task automatic do_cycle(input bit w, input logic [11:0] a, input logic [7:0] d,
                          output int ce_lo, output int we_lo, output int rd_lo,
                          output logic [7:0] rd, output bit addr_ok);
    ce_lo = 0; we_lo = 0; rd_lo = 0; addr_ok = 1;
    while (!ready) @(negedge clk);
    req = 1; we = w; addr = a; wdata = d;
    @(negedge clk);
    req = 0; addr = ~a; wdata = ~d;
    for (int i = 0; i < 60 && !done; i++) begin
      if (!ce_n) begin ce_lo++; if (maddr != a) addr_ok = 0; end
      if (!we_n) we_lo++;
      if (!ce_n && !oe_n && we_n) rd_lo++;
      @(negedge clk);
    end
    rd = rdata;
  endtask

  task automatic t_reset;
    check(ce_n && we_n && oe_n, "R1 strobes", {ce_n, we_n, oe_n}, 3'b111);
    check(!dq_oe && !done && ready, "R1 status", {dq_oe, done, ready}, 3'b001);
  endtask

  task automatic t_write_read(input logic [11:0] a, input logic [7:0] d);
    int c, w, r; logic [7:0] q; bit ok;
    do_cycle(1, a, d, c, w, r, q, ok);
    check(w == PW, "R3 pulse", w, PW);
    check(c == PW + 1, "R9 ce span", c, PW + 1);
    check(ok, "R5 write addr", ok, 1);
    check(done && ce_n && !ready, "R8 done write", {done, ce_n, ready}, 3'b110);
    @(negedge clk);
    check(!done && ce_n && !ready, "R7 rec", {done, ce_n, ready}, 3'b010);
    do_cycle(0, a, 8'h00, c, w, r, q, ok);
    check(r == RD && c == RD && w == 0, "R2 access len", r, RD);
    check(q == d, "R2 rdata", q, d);
    check(ok, "R5 read addr", ok, 1);
    @(negedge clk);
    check(!done, "R8 done width", done, 0);
  endtask

  task automatic t_busy_ignore;
    int c, w, r; logic [7:0] q, old; bit ok;
    do_cycle(0, 12'h0A5, 8'h00, c, w, r, old, ok);
    while (!ready) @(negedge clk);
    req = 1; we = 1; addr = 12'h300; wdata = 8'h3C;
    @(negedge clk);
    addr = 12'h0A5; wdata = 8'hC3;
    for (int i = 0; i < 3; i++) begin
      check(maddr == 12'h300 && !ready, "R6 busy addr", maddr, 12'h300);
      @(negedge clk);
    end
    req = 0;
    while (!ready) @(negedge clk);
    do_cycle(0, 12'h0A5, 8'h00, c, w, r, q, ok);
    check(q == old, "R6 ignored write", q, old);
    do_cycle(0, 12'h300, 8'h00, c, w, r, q, ok);
    check(q == 8'h3C, "R6 accepted write", q, 8'h3C);
  endtask

  task automatic t_b2b;
    int gap = 0;
    while (!ready) @(negedge clk);
    req = 1; we = 0; addr = 12'h010;
    @(negedge clk);
    while (!done) @(negedge clk);
    while (ce_n && gap < 20) begin gap++; @(negedge clk); end
    req = 0;
    check(gap >= REC + 1, "R7 ce gap", gap, REC + 1);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'(i) ^ 8'h5A;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_write_read(12'h123, 8'hA7);
    t_write_read(12'h000, 8'h00);
    t_write_read(12'hFFF, 8'hFF);
    t_write_read(12'h800, 8'h81);
    t_busy_ignore();
    t_b2b();
    repeat (4) @(negedge clk);
    check(viol == 0, "R4 model rules", viol, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    #(200000 * 10);
    nvec++; nerr++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule